// File: doc/BRIEF.md
# Successive-Approximation Controller with Tri-Level LSB Voting

This block sequences the binary search of a successive-approximation converter built around a fully differential capacitive DAC. A single-cycle start request begins a conversion. Each conversion opens at midscale. On every cycle that the comparator is strobed, the block takes one decision bit back. It drives an N-bit control word to the positive capacitor network and the bitwise complement of that word to the negative network. When the search ends, it presents the final code together with a one-cycle completion pulse.

The upper bits are each settled by one comparison. The two least significant bits are treated differently because comparator noise dominates there. For each of those two bits the comparator is strobed a parameterised number of times and the bit is settled by a tri-level vote: clear one, clear zero, or undecided. An undecided vote settles the bit to zero and raises a flag that travels with the result. A residue request given with the start adds one extra cycle after the last decision. During that cycle the final word stays on the DAC so that an external loop filter can capture the residual quantisation error.

Top module: `sar_vote_ctrl`

## Requirements
- R1: A start accepted while idle puts the midscale word (only bit N-1 set) on the positive network in the first conversion cycle.
- R2: The negative-network word is the bitwise complement of the positive-network word in every cycle, including reset.
- R3: After a decision on bit i, bit i keeps its trial value of 1 when the decision is 1 and is cleared when it is 0. For i > 0, bit i-1 is then set as the next trial.
- R4: Without a residue request, the completion pulse appears (N-2) + 2*VOTES + 1 cycles after the start is sampled. With a residue request it appears one cycle later.
- R5: Bits N-1 down to 2 each use exactly one comparator strobe. Bits 1 and 0 each use exactly VOTES strobes, so a conversion has (N-2) + 2*VOTES strobes in total.
- R6: For a voted bit with k ones out of VOTES samples, 4k >= 3*VOTES settles the bit to 1 and 4k <= VOTES settles it to 0. With VOTES=4 this means three or more ones give 1 and at most one 1 gives 0.
- R7: A vote between those bounds (a 2–2 split with VOTES=4) settles the bit to 0 and sets the undecided output, which stays high with the code until the next start.
- R8: When a residue request is sampled with the start, residue_sample is high for exactly one cycle, directly before the completion pulse, and the comparator is not strobed in that cycle.
- R9: A start pulse that arrives while busy has no effect: the running conversion finishes with its normal timing and result, and no further completion follows.
- R10: done is high for exactly one cycle. In that cycle, code holds the converted value and equals the word on the positive network.
- R11: cmp_fire is high only while a conversion is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, honoured only while idle |
| residue_req | input | 1 | Sampled with start; adds the residue cycle |
| cmp_in | input | 1 | Comparator decision, 1 when the negative node is below the positive node |
| cmp_fire | output | 1 | Comparator strobe for the current cycle |
| dac_pos | output | N | Control word for the positive capacitor network |
| dac_neg | output | N | Complementary control word for the negative network |
| residue_sample | output | 1 | High during the optional residue cycle |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result-valid pulse |
| code | output | N | Final conversion result |
| undecided | output | 1 | At least one voted LSB had an undecided vote |

## Verification
The bench builds the controller with N=6 and VOTES=4. This makes the whole input range of 64 levels small enough to convert one by one, with and without the residue cycle. It also makes every 4-sample vote pattern for bit 1 crossed with every pattern for bit 0 (256 pairs) a short sweep. As a result, each tri-level outcome, including both undecided positions, is reached against an arithmetically computed code.

// File: rtl/sar_vote_pkg.sv
package sar_vote_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_RESID = 2'd2,
    ST_DONE  = 2'd3
  } sar_state_e;

  // Tri-level verdict over a vote: {uncertain, bit}.
  // 4*ones >= 3*total -> firm one; 4*ones <= total -> firm zero; else uncertain (bit 0).
  function automatic logic [1:0] vote_verdict(input int unsigned ones, input int unsigned total);
    logic [1:0] r;
    if (4 * ones >= 3 * total)  r = 2'b01;
    else if (4 * ones <= total) r = 2'b00;
    else                        r = 2'b10;
    return r;
  endfunction

endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_vote_pkg::*;
#(
  parameter int N          = 10,
  parameter int VOTES      = 4,
  parameter int VOTED_BITS = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int VW = (VOTES > 1) ? $clog2(VOTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          residue_req,
  output sar_state_e    state,
  output logic [IW-1:0] bit_idx,
  output logic [VW-1:0] vote_cnt,
  output logic          launch,
  output logic          voting,
  output logic          last_vote,
  output logic          step,
  output logic          final_step,
  output logic          busy,
  output logic          fire,
  output logic          resid_phase,
  output logic          done
);

  localparam logic [IW-1:0] TOP_IDX  = IW'(N - 1);
  localparam logic [IW-1:0] VOTE_LIM = IW'(VOTED_BITS);
  localparam logic [VW-1:0] LAST_V   = VW'(VOTES - 1);

  logic resid_lat;

  assign launch      = (state == ST_IDLE) && start;
  assign fire        = (state == ST_CONV);
  assign voting      = fire && (bit_idx < VOTE_LIM);
  assign last_vote   = (vote_cnt == LAST_V);
  assign step        = fire && (!voting || last_vote);
  assign final_step  = step && (bit_idx == '0);
  assign busy        = (state != ST_IDLE);
  assign resid_phase = (state == ST_RESID);
  assign done        = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_idx   <= '0;
      vote_cnt  <= '0;
      resid_lat <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_CONV;
          bit_idx   <= TOP_IDX;
          vote_cnt  <= '0;
          resid_lat <= residue_req;
        end
        ST_CONV: begin
          if (voting) vote_cnt <= last_vote ? '0 : vote_cnt + 1'b1;
          if (step) begin
            if (bit_idx == '0) state <= resid_lat ? ST_RESID : ST_DONE;
            else               bit_idx <= bit_idx - 1'b1;
          end
        end
        ST_RESID: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R9: a start seen mid-conversion must not reload the bit pointer
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && start && !step) |=> (bit_idx == $past(bit_idx)));

  // R5: the vote counter never passes the configured vote count
  a_r5_vote_bound: assert property (@(posedge clk) disable iff (!rst_n)
    voting |-> (int'(vote_cnt) < VOTES));

  // R8: the residue cycle lasts one cycle and leads straight into completion
  a_r8_resid_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    resid_phase |=> done);

  // R10: completion lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/sar_vote_tally.sv
module sar_vote_tally
  import sar_vote_pkg::*;
#(
  parameter int VOTES = 4,
  localparam int CW = $clog2(VOTES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic last,
  input  logic cmp_in,
  output logic verdict_bit,
  output logic verdict_unc
);

  logic [CW-1:0] ones;
  logic [CW-1:0] ones_now;
  logic [1:0]    verdict;

  assign ones_now    = ones + CW'(cmp_in);
  assign verdict     = vote_verdict(int'(ones_now), VOTES);
  assign verdict_bit = verdict[0];
  assign verdict_unc = verdict[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ones <= '0;
    else if (sample) ones <= last ? '0 : ones_now;
  end

  // R6: the running tally is empty at the start of every vote and stays below the vote count
  a_r6_tally_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (int'(ones) < VOTES));

  a_r6_tally_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && last) |=> (ones == '0));

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int N = 10,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [IW-1:0] bit_idx,
  input  logic          decision,
  output logic [N-1:0]  word,
  output logic [N-1:0]  word_next
);

  localparam logic [N-1:0] MID = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] sel_hot;
  logic [N-1:0] next_hot;

  assign sel_hot  = N'(1) << bit_idx;
  assign next_hot = sel_hot >> 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (sel_hot[i])       word_next[i] = decision;
      else if (next_hot[i]) word_next[i] = 1'b1;
      else                  word_next[i] = word[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (load) word <= MID;
    else if (step) word <= word_next;
  end

  // R1: a launch opens at midscale
  a_r1_midscale: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (word == MID));

  // R3: a one keeps the trial bit, a zero drops it, the next lower bit becomes the trial
  a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (step && decision) |=> ((word & $past(sel_hot)) != '0));

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !decision) |=> ((word & $past(sel_hot)) == '0));

  a_r3_next_set: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((word & $past(next_hot)) == $past(next_hot)));

endmodule

// File: rtl/sar_vote_ctrl.sv
module sar_vote_ctrl
  import sar_vote_pkg::*;
#(
  parameter int N     = 10,
  parameter int VOTES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         residue_req,
  input  logic         cmp_in,
  output logic         cmp_fire,
  output logic [N-1:0] dac_pos,
  output logic [N-1:0] dac_neg,
  output logic         residue_sample,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] code,
  output logic         undecided
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int VW = (VOTES > 1) ? $clog2(VOTES) : 1;

  sar_state_e    state;
  logic [IW-1:0] bit_idx;
  logic [VW-1:0] vote_cnt;
  logic          launch, voting, last_vote, step, final_step;
  logic          verdict_bit, verdict_unc, decision;
  logic [N-1:0]  word, word_next;

  sar_seq_fsm #(.N(N), .VOTES(VOTES), .VOTED_BITS(2)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .residue_req(residue_req),
    .state(state), .bit_idx(bit_idx), .vote_cnt(vote_cnt),
    .launch(launch), .voting(voting), .last_vote(last_vote), .step(step),
    .final_step(final_step), .busy(busy), .fire(cmp_fire),
    .resid_phase(residue_sample), .done(done)
  );

  sar_vote_tally #(.VOTES(VOTES)) u_tally (
    .clk(clk), .rst_n(rst_n), .sample(voting), .last(last_vote),
    .cmp_in(cmp_in), .verdict_bit(verdict_bit), .verdict_unc(verdict_unc)
  );

  assign decision = voting ? verdict_bit : cmp_in;

  sar_trial_reg #(.N(N)) u_trial (
    .clk(clk), .rst_n(rst_n), .load(launch), .step(step),
    .bit_idx(bit_idx), .decision(decision),
    .word(word), .word_next(word_next)
  );

  assign dac_pos = word;
  assign dac_neg = ~word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code      <= '0;
      undecided <= 1'b0;
    end else begin
      if (launch)                             undecided <= 1'b0;
      else if (step && voting && verdict_unc) undecided <= 1'b1;
      if (final_step) code <= word_next;
    end
  end

  // R7: an undecided vote leaves the bit at zero and raises the flag
  a_r7_unc_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (step && voting && verdict_unc) |=> (undecided && !dac_pos[$past(bit_idx)]));

  // R10: the code presented with completion matches the word on the DAC
  a_r10_code_match: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (code == dac_pos));

  // R11: the comparator is strobed only during a conversion
  a_r11_fire_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |-> busy);

  // R8: no strobe during the residue cycle
  a_r8_no_fire_resid: assert property (@(posedge clk) disable iff (!rst_n)
    residue_sample |-> !cmp_fire);

endmodule

// File: tb/tb_sar_vote_ctrl.sv
module tb_sar_vote_ctrl;

  localparam int N   = 6;
  localparam int V   = 4;
  localparam int C   = (N - 2) + 2 * V;
  localparam logic [N-1:0] MID = 6'b100000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, residue_req, cmp_in;
  logic cmp_fire, residue_sample, busy, done, undecided;
  logic [N-1:0] dac_pos, dac_neg, code;

  int nchk = 0, nfail = 0;
  int vin = 0;
  bit vote_mode = 0;
  logic [V-1:0] pat1 = '0, pat0 = '0;
  int fire_n = 0;
  int kk;

  sar_vote_ctrl #(.N(N), .VOTES(V)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .residue_req(residue_req),
    .cmp_in(cmp_in), .cmp_fire(cmp_fire), .dac_pos(dac_pos), .dac_neg(dac_neg),
    .residue_sample(residue_sample), .busy(busy), .done(done),
    .code(code), .undecided(undecided)
  );

  // strobe counter since the accepted start
  always_ff @(posedge clk) begin
    if (start && !busy)  fire_n <= 0;
    else if (cmp_fire)   fire_n <= fire_n + 1;
  end

  // behavioural comparator: ideal for upper bits, scripted samples for the voted bits
  always_comb begin
    kk = fire_n - (N - 2);
    if (!vote_mode || fire_n < N - 2) cmp_in = (vin >= int'(dac_pos));
    else if (kk < V)                  cmp_in = pat1[kk];
    else if (kk < 2 * V)              cmp_in = pat0[kk - V];
    else                              cmp_in = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_vote(input logic [V-1:0] p);
    // returns {undecided, bit}
    case ($countones(p))
      0, 1:    return 2'b00;
      2:       return 2'b10;
      default: return 2'b01;
    endcase
  endfunction

  task automatic run_conv(input int v, input bit res, input bit vm,
                          input logic [V-1:0] p1, input logic [V-1:0] p0,
                          input bit poke, input int exp_code, input bit exp_unc);
    int lat, fires, rs, first;
    bit compl_ok, late_done;
    vin = v; vote_mode = vm; pat1 = p1; pat0 = p0;
    @(negedge clk); start = 1'b1; residue_req = res;
    @(negedge clk); start = 1'b0; residue_req = 1'b0;
    lat = 1; fires = 0; rs = 0; compl_ok = 1'b1;
    chk(dac_pos == MID, "R1", int'(dac_pos), int'(MID));
    while (!done && lat < 100) begin
      compl_ok &= (dac_neg == ~dac_pos);
      fires += int'(cmp_fire);
      rs    += int'(residue_sample);
      if (lat == 2) begin
        first = ((v >= 32) ? 32 : 0) + 16;
        chk(int'(dac_pos) == first, "R3", int'(dac_pos), first);
      end
      if (poke && lat == 3) start = 1'b1;
      if (poke && lat == 4) start = 1'b0;
      @(negedge clk);
      lat++;
    end
    compl_ok &= (dac_neg == ~dac_pos);
    chk(lat == C + 1 + int'(res), "R4", lat, C + 1 + int'(res));
    chk(fires == C, "R5", fires, C);
    chk(rs == int'(res), "R8", rs, int'(res));
    chk(int'(code) == exp_code, vm ? "R6" : "R3", int'(code), exp_code);
    chk(code == dac_pos, "R10", int'(dac_pos), int'(code));
    chk(undecided == exp_unc, "R7", int'(undecided), int'(exp_unc));
    chk(compl_ok, "R2", int'(compl_ok), 1);
    @(negedge clk);
    chk(!done && !busy, "R10", int'(done), 0);
    if (poke) begin
      late_done = 1'b0;
      for (int i = 0; i < 20; i++) begin
        late_done |= done | busy | cmp_fire;
        @(negedge clk);
      end
      chk(!late_done, "R9", int'(late_done), 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [1:0] e1, e0;
    rst_n = 1'b0; start = 1'b0; residue_req = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    chk(dac_pos == '0, "R2", int'(dac_pos), 0);
    chk(dac_neg == '1, "R2", int'(dac_neg), 63);
    chk(!busy && !done && !cmp_fire && !residue_sample, "R11", int'(cmp_fire), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cmp_fire, "R11", int'(cmp_fire), 0);

    // every input level, residue cycle on odd levels
    for (int v = 0; v < 64; v++)
      run_conv(v, bit'(v % 2), 1'b0, '0, '0, 1'b0, v, 1'b0);

    // every vote pattern pair on the two voted bits (upper bits 1011)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        e1 = exp_vote(4'(a));
        e0 = exp_vote(4'(b));
        run_conv(44, bit'((a + b) % 3 == 0), 1'b1, 4'(a), 4'(b), 1'b0,
                 44 + 2 * int'(e1[0]) + int'(e0[0]), e1[1] | e0[1]);
      end
    end

    // start pulses while busy (R9), with and without residue
    run_conv(37, 1'b1, 1'b0, '0, '0, 1'b1, 37, 1'b0);
    run_conv(12, 1'b0, 1'b0, '0, '0, 1'b1, 12, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule